// File: doc/BRIEF.md
# Vehicle Event Timestamp Reporter

This block keeps a time of day for a parking facility controller and stamps vehicle movements with it. A free-running time base advances once per cycle of a 1 ms system clock. It holds a millisecond, a second, a minute and an hour counter, all clocked from that one clock and chained by carry enables. Whenever the occupancy logic issues a one-cycle entry or exit pulse, the current hour and minute are copied into a dedicated register for that kind of event. A one-cycle strobe announces the new value.

An external midnight pulse puts the whole time base back to 00:00:00.000, so that the reported times stay aligned with the wall clock. Entry and exit pulses may arrive in the same cycle, and each is stamped independently. The number of ticks per second, seconds per minute, minutes per hour and hours per day are parameters. Their defaults describe a real day on a 1 ms clock.

Top module: `ets_event_stamper`

## Requirements
- R1: While reset is high, and in the first cycle after it falls, both stamps read hour 0 and minute 0 and both strobes are low; the time base restarts from zero.
- R2: The time base advances one tick per clock cycle. The minute value grows by one after every TICKS_PER_SEC × SEC_PER_MIN cycles, which is 60 000 cycles with the defaults.
- R3: The minute value runs from 0 to MIN_PER_HOUR−1, then returns to 0 and raises the hour by one. The stamp presents it as an unsigned binary number on 6 bits.
- R4: The hour value runs from 0 to HOURS_PER_DAY−1 and then returns to 0. The stamp presents it as an unsigned binary number on 5 bits.
- R5: A cycle with the midnight pulse high clears the millisecond, second, minute and hour counters. Counting resumes from zero in the cycle after.
- R6: An entry pulse copies the hour and minute present in its cycle into the entry stamp. The entry strobe is high for exactly the one cycle after that pulse.
- R7: An exit pulse copies the hour and minute present in its cycle into the exit stamp. The exit strobe is high for exactly the one cycle after that pulse.
- R8: Entry and exit pulses in the same cycle both capture that cycle's time, and both strobes rise together.
- R9: An event in the same cycle as the midnight pulse captures the time as it was before the clear.
- R10: A stamp keeps its value in every cycle without its own event. An entry never disturbs the exit stamp, and an exit never disturbs the entry stamp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, one tick per period |
| rst | input | 1 | Synchronous reset, active high |
| midnight_sync | input | 1 | Clears the time base to 00:00 |
| entry_evt | input | 1 | One-cycle pulse for a vehicle entering |
| exit_evt | input | 1 | One-cycle pulse for a vehicle leaving |
| entry_hr | output | 5 | Hour of the latest entry |
| entry_min | output | 6 | Minute of the latest entry |
| entry_vld | output | 1 | One-cycle strobe after an entry capture |
| exit_hr | output | 5 | Hour of the latest exit |
| exit_min | output | 6 | Minute of the latest exit |
| exit_vld | output | 1 | One-cycle strobe after an exit capture |

## Verification
The bench builds the block with 4 ticks per second, 3 seconds per minute, 5 minutes per hour and 3 hours per day. A minute therefore lasts 12 cycles and a whole day 180 cycles. With these values the minute carry, the hour carry and the day wrap all fall within a few hundred cycles, so events can be stamped right at each boundary and at the midnight clear. The counters are the same modules as in the default build, which only has larger moduli.

// File: rtl/ets_pkg.sv
package ets_pkg;

  localparam int unsigned HR_W  = 5;
  localparam int unsigned MIN_W = 6;

  typedef struct packed {
    logic [HR_W-1:0]  hr;
    logic [MIN_W-1:0] mn;
  } hhmm_t;

  // Width needed to hold 0 .. modulus-1
  function automatic int unsigned width_for(input int unsigned modulus);
    return (modulus <= 2) ? 1 : $clog2(modulus);
  endfunction

  // True when a counter sits on its last value
  function automatic logic at_top(input int unsigned value, input int unsigned modulus);
    return value == modulus - 1;
  endfunction

  // Next value of a modulo counter
  function automatic int unsigned mod_step(input int unsigned value, input int unsigned modulus);
    return (value + 1 >= modulus) ? 0 : value + 1;
  endfunction

endpackage

// File: rtl/ets_mod_counter.sv
module ets_mod_counter #(
  parameter int unsigned MODULUS = 60,
  parameter int unsigned W       = ets_pkg::width_for(MODULUS)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] value,
  output logic         carry
);

  logic [W-1:0] value_q;

  // carry is an enable for the next stage, never a clock
  always_comb begin
    carry = inc && ets_pkg::at_top(32'(value_q), MODULUS);
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      value_q <= '0;
    end else if (inc) begin
      value_q <= W'(ets_pkg::mod_step(32'(value_q), MODULUS));
    end
  end

  assign value = value_q;

endmodule

// File: rtl/ets_timebase.sv
module ets_timebase #(
  parameter int unsigned TICKS_PER_SEC = 1000,
  parameter int unsigned SEC_PER_MIN   = 60,
  parameter int unsigned MIN_PER_HOUR  = 60,
  parameter int unsigned HOURS_PER_DAY = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sync_clr,
  output ets_pkg::hhmm_t now,
  output logic          tick_carry,
  output logic          sec_carry,
  output logic          min_carry,
  output logic          hr_carry
);

  localparam int unsigned TICK_W = ets_pkg::width_for(TICKS_PER_SEC);
  localparam int unsigned SEC_W  = ets_pkg::width_for(SEC_PER_MIN);

  logic [TICK_W-1:0]          tick_val;
  logic [SEC_W-1:0]           sec_val;
  logic [ets_pkg::MIN_W-1:0]  min_val;
  logic [ets_pkg::HR_W-1:0]   hr_val;

  ets_mod_counter #(.MODULUS(TICKS_PER_SEC), .W(TICK_W)) u_tick (
    .clk(clk), .rst(rst), .clr(sync_clr), .inc(1'b1),
    .value(tick_val), .carry(tick_carry)
  );

  ets_mod_counter #(.MODULUS(SEC_PER_MIN), .W(SEC_W)) u_sec (
    .clk(clk), .rst(rst), .clr(sync_clr), .inc(tick_carry),
    .value(sec_val), .carry(sec_carry)
  );

  ets_mod_counter #(.MODULUS(MIN_PER_HOUR), .W(ets_pkg::MIN_W)) u_min (
    .clk(clk), .rst(rst), .clr(sync_clr), .inc(sec_carry),
    .value(min_val), .carry(min_carry)
  );

  ets_mod_counter #(.MODULUS(HOURS_PER_DAY), .W(ets_pkg::HR_W)) u_hr (
    .clk(clk), .rst(rst), .clr(sync_clr), .inc(min_carry),
    .value(hr_val), .carry(hr_carry)
  );

  always_comb begin
    now.hr = hr_val;
    now.mn = min_val;
  end

endmodule

// File: rtl/ets_stamp_reg.sv
module ets_stamp_reg (
  input  logic           clk,
  input  logic           rst,
  input  logic           evt,
  input  ets_pkg::hhmm_t now,
  output ets_pkg::hhmm_t stamp,
  output logic           vld
);

  ets_pkg::hhmm_t stamp_q;
  logic           vld_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stamp_q <= '0;
      vld_q   <= 1'b0;
    end else begin
      vld_q <= evt;
      if (evt) begin
        stamp_q <= now;
      end
    end
  end

  assign stamp = stamp_q;
  assign vld   = vld_q;

endmodule

// File: rtl/ets_event_stamper.sv
module ets_event_stamper #(
  parameter int unsigned TICKS_PER_SEC = 1000,
  parameter int unsigned SEC_PER_MIN   = 60,
  parameter int unsigned MIN_PER_HOUR  = 60,
  parameter int unsigned HOURS_PER_DAY = 24
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       midnight_sync,
  input  logic       entry_evt,
  input  logic       exit_evt,
  output logic [4:0] entry_hr,
  output logic [5:0] entry_min,
  output logic       entry_vld,
  output logic [4:0] exit_hr,
  output logic [5:0] exit_min,
  output logic       exit_vld
);

  localparam int unsigned N_CH = 2;  // channel 0 entry, channel 1 exit

  ets_pkg::hhmm_t now_t;
  logic           tick_carry;
  logic           sec_carry;
  logic           min_carry;
  logic           hr_carry;

  // named internal events for the checker
  logic [4:0] now_hr;
  logic [5:0] now_min;

  ets_timebase #(
    .TICKS_PER_SEC(TICKS_PER_SEC),
    .SEC_PER_MIN  (SEC_PER_MIN),
    .MIN_PER_HOUR (MIN_PER_HOUR),
    .HOURS_PER_DAY(HOURS_PER_DAY)
  ) u_timebase (
    .clk       (clk),
    .rst       (rst),
    .sync_clr  (midnight_sync),
    .now       (now_t),
    .tick_carry(tick_carry),
    .sec_carry (sec_carry),
    .min_carry (min_carry),
    .hr_carry  (hr_carry)
  );

  assign now_hr  = now_t.hr;
  assign now_min = now_t.mn;

  logic [N_CH-1:0] evt_vec;
  logic [N_CH-1:0] vld_vec;
  ets_pkg::hhmm_t  stamp_arr [N_CH];

  assign evt_vec = {exit_evt, entry_evt};

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
    ets_stamp_reg u_stamp (
      .clk  (clk),
      .rst  (rst),
      .evt  (evt_vec[ch]),
      .now  (now_t),
      .stamp(stamp_arr[ch]),
      .vld  (vld_vec[ch])
    );
  end

  assign entry_hr  = stamp_arr[0].hr;
  assign entry_min = stamp_arr[0].mn;
  assign entry_vld = vld_vec[0];
  assign exit_hr   = stamp_arr[1].hr;
  assign exit_min  = stamp_arr[1].mn;
  assign exit_vld  = vld_vec[1];

endmodule

// File: rtl/ets_event_stamper_chk.sv
module ets_event_stamper_chk #(
  parameter int unsigned MIN_PER_HOUR  = 60,
  parameter int unsigned HOURS_PER_DAY = 24
) (
  input logic       clk,
  input logic       rst,
  input logic       midnight_sync,
  input logic       entry_evt,
  input logic       exit_evt,
  input logic [4:0] entry_hr,
  input logic [5:0] entry_min,
  input logic       entry_vld,
  input logic [4:0] exit_hr,
  input logic [5:0] exit_min,
  input logic       exit_vld,
  input logic [4:0] now_hr,
  input logic [5:0] now_min,
  input logic       min_carry
);

  AST_ENTRY_STROBE: assert property (@(posedge clk) disable iff (rst)
    entry_evt |=> entry_vld);  // R6
  AST_ENTRY_STROBE_LOW: assert property (@(posedge clk) disable iff (rst)
    !entry_evt |=> !entry_vld);  // R6
  AST_ENTRY_VALUE: assert property (@(posedge clk) disable iff (rst)
    entry_evt |=> (entry_hr == $past(now_hr)) && (entry_min == $past(now_min)));  // R6
  AST_EXIT_STROBE: assert property (@(posedge clk) disable iff (rst)
    exit_evt |=> exit_vld);  // R7
  AST_EXIT_VALUE: assert property (@(posedge clk) disable iff (rst)
    exit_evt |=> (exit_hr == $past(now_hr)) && (exit_min == $past(now_min)));  // R7
  AST_PAIR_MATCH: assert property (@(posedge clk) disable iff (rst)
    (entry_evt && exit_evt) |=> (entry_hr == exit_hr) && (entry_min == exit_min));  // R8
  AST_ENTRY_HOLD: assert property (@(posedge clk) disable iff (rst)
    !entry_evt |=> $stable(entry_hr) && $stable(entry_min));  // R10
  AST_EXIT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !exit_evt |=> $stable(exit_hr) && $stable(exit_min));  // R10
  AST_SYNC_CLEAR: assert property (@(posedge clk) disable iff (rst)
    midnight_sync |=> (now_hr == 5'd0) && (now_min == 6'd0));  // R5
  AST_MIN_RANGE: assert property (@(posedge clk) disable iff (rst)
    32'(now_min) < MIN_PER_HOUR);  // R3
  AST_HR_RANGE: assert property (@(posedge clk) disable iff (rst)
    32'(now_hr) < HOURS_PER_DAY);  // R4
  AST_DAY_WRAP: assert property (@(posedge clk) disable iff (rst)
    (min_carry && !midnight_sync && 32'(now_hr) == HOURS_PER_DAY - 1) |=> now_hr == 5'd0);  // R4

endmodule

bind ets_event_stamper ets_event_stamper_chk #(
  .MIN_PER_HOUR (MIN_PER_HOUR),
  .HOURS_PER_DAY(HOURS_PER_DAY)
) u_chk (.*);

// File: tb/ets_event_stamper_test.sv
module ets_event_stamper_test;

  localparam int TPS = 4;
  localparam int SPM = 3;
  localparam int MPH = 5;
  localparam int HPD = 3;
  localparam int CYC_PER_MIN = TPS * SPM;
  localparam int CYC_PER_HR  = CYC_PER_MIN * MPH;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       midnight_sync = 1'b0;
  logic       entry_evt = 1'b0;
  logic       exit_evt = 1'b0;
  logic [4:0] entry_hr;
  logic [5:0] entry_min;
  logic       entry_vld;
  logic [4:0] exit_hr;
  logic [5:0] exit_min;
  logic       exit_vld;

  int compared = 0;
  int mismatched = 0;
  int t = 0;          // ticks since last reset or midnight pulse
  int last_en_hr = 0, last_en_min = 0, last_ex_hr = 0, last_ex_min = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ets_event_stamper #(
    .TICKS_PER_SEC(TPS), .SEC_PER_MIN(SPM), .MIN_PER_HOUR(MPH), .HOURS_PER_DAY(HPD)
  ) uut (
    .clk(clk), .rst(rst), .midnight_sync(midnight_sync),
    .entry_evt(entry_evt), .exit_evt(exit_evt),
    .entry_hr(entry_hr), .entry_min(entry_min), .entry_vld(entry_vld),
    .exit_hr(exit_hr), .exit_min(exit_min), .exit_vld(exit_vld)
  );

  // reference tick count built from the requirements
  always @(posedge clk) begin
    if (rst || midnight_sync) t <= 0;
    else                      t <= t + 1;
  end

  function automatic int exp_min(input int ticks);
    return (ticks / CYC_PER_MIN) % MPH;
  endfunction

  function automatic int exp_hr(input int ticks);
    return (ticks / CYC_PER_HR) % HPD;
  endfunction

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_stamps(input string req);
    check(entry_hr == 5'(last_en_hr), req, "entry_hr", entry_hr, last_en_hr);
    check(entry_min == 6'(last_en_min), req, "entry_min", entry_min, last_en_min);
    check(exit_hr == 5'(last_ex_hr), req, "exit_hr", exit_hr, last_ex_hr);
    check(exit_min == 6'(last_ex_min), req, "exit_min", exit_min, last_ex_min);
  endtask

  task automatic advance_to(input int target);
    while (t != target) @(negedge clk);
  endtask

  // drive one cycle of stimulus at a negedge, check the cycle after
  task automatic fire(input bit en, input bit ex, input bit sy, input string req);
    int cap = t;
    entry_evt = en;
    exit_evt = ex;
    midnight_sync = sy;
    @(negedge clk);
    entry_evt = 1'b0;
    exit_evt = 1'b0;
    midnight_sync = 1'b0;
    if (en) begin last_en_hr = exp_hr(cap); last_en_min = exp_min(cap); end
    if (ex) begin last_ex_hr = exp_hr(cap); last_ex_min = exp_min(cap); end
    check(entry_vld == en, req, "entry_vld", entry_vld, en);
    check(exit_vld == ex, req, "exit_vld", exit_vld, ex);
    check_stamps(req);
    @(negedge clk);
    check(entry_vld == 1'b0, req, "entry_vld drop", entry_vld, 0);
    check(exit_vld == 1'b0, req, "exit_vld drop", exit_vld, 0);
    check_stamps(req);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    last_en_hr = 0; last_en_min = 0; last_ex_hr = 0; last_ex_min = 0;
    check(entry_vld == 1'b0 && exit_vld == 1'b0, "R1", "strobes in reset", entry_vld, 0);
    check_stamps("R1");
    rst = 1'b0;
    @(negedge clk);
    check(entry_vld == 1'b0 && exit_vld == 1'b0, "R1", "strobes after reset", exit_vld, 0);
    check_stamps("R1");
  endtask

  task automatic t_entry_walk();
    // first cycle after reset reads 00:00
    fire(1'b1, 1'b0, 1'b0, "R1");
    advance_to(CYC_PER_MIN - 1);
    fire(1'b1, 1'b0, 1'b0, "R2");         // last tick of minute 0
    fire(1'b1, 1'b0, 1'b0, "R2");         // minute 1 reached? (t moved past)
    advance_to(2 * CYC_PER_MIN);
    fire(1'b1, 1'b0, 1'b0, "R2");
    advance_to(CYC_PER_HR - 1);
    fire(1'b1, 1'b0, 1'b0, "R3");         // 00:04
    advance_to(CYC_PER_HR + 1);
    fire(1'b1, 1'b0, 1'b0, "R3");         // 01:00
    check(entry_hr == 5'd1 && entry_min == 6'd0, "R3", "minute wrap into hour", entry_min, 0);
  endtask

  task automatic t_exit_only();
    advance_to(CYC_PER_HR + 3 * CYC_PER_MIN + 5);
    fire(1'b0, 1'b1, 1'b0, "R7");
    check(exit_hr == 5'd1 && exit_min == 6'd3, "R7", "exit stamp 01:03", exit_min, 3);
    fire(1'b1, 1'b0, 1'b0, "R10");       // entry leaves exit stamp alone
  endtask

  task automatic t_both();
    advance_to(2 * CYC_PER_HR + 2 * CYC_PER_MIN);
    fire(1'b1, 1'b1, 1'b0, "R8");
    check(entry_hr == 5'd2 && exit_hr == 5'd2, "R8", "pair hour", exit_hr, 2);
  endtask

  task automatic t_day_wrap();
    advance_to(HPD * CYC_PER_HR - 1);
    fire(1'b0, 1'b1, 1'b0, "R4");
    check(exit_hr == 5'(HPD - 1) && exit_min == 6'(MPH - 1), "R4", "last minute of day", exit_hr, HPD - 1);
    fire(1'b1, 1'b0, 1'b0, "R4");
    check(entry_hr == 5'd0 && entry_min == 6'd0, "R4", "day wrap to 00:00", entry_hr, 0);
  endtask

  task automatic t_sync();
    advance_to(HPD * CYC_PER_HR + CYC_PER_HR + 2 * CYC_PER_MIN);
    fire(1'b0, 1'b0, 1'b1, "R5");
    advance_to(CYC_PER_MIN + 2);
    fire(1'b1, 1'b0, 1'b0, "R5");
    check(entry_hr == 5'd0 && entry_min == 6'd1, "R5", "count resumes from zero", entry_min, 1);
  endtask

  task automatic t_sync_event();
    advance_to(CYC_PER_HR + CYC_PER_MIN);
    fire(1'b1, 1'b1, 1'b1, "R9");
    check(entry_hr == 5'd1 && entry_min == 6'd1, "R9", "pre-clear time kept", entry_min, 1);
    fire(1'b1, 1'b0, 1'b0, "R9");
    check(entry_hr == 5'd0 && entry_min == 6'd0, "R9", "time after clear", entry_min, 0);
  endtask

  task automatic t_hold();
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      check(entry_vld == 1'b0 && exit_vld == 1'b0, "R10", "idle strobe", entry_vld, 0);
    end
    check_stamps("R10");
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_entry_walk();
    t_exit_only();
    t_both();
    t_day_wrap();
    t_sync();
    t_sync_event();
    t_hold();
    t_reset();
    fire(1'b1, 1'b1, 1'b0, "R1");
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule